// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block resolves data and control hazards for an in-order integer pipeline with five stages: instruction fetch, decode with register-file read, execute, memory access and writeback. Each cycle it receives the decoded fields of the instruction that sits in decode. These are the source specifiers, the source-use flags, the destination, the write-enable flag and the load flag. It also receives the taken indication of a branch resolved in execute. It keeps its own copy of the control fields of the three older stages in small pipeline registers.

From this state it drives three groups of signals. The first is a bypass select for each execute operand, which picks the register file, the memory-stage result or the writeback-stage result. The second is a front-end hold with a bubble into execute when a consumer directly follows a load. The third is a flush of the two younger stages when a branch in execute is taken. The fetch, decode and execute datapaths use these controls, so dependent ALU operations run back to back and one instruction completes per cycle when no hazard is present.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: After reset is released, with no valid instruction in decode and no taken branch, both bypass selects read 2'b00 and stall_front, bubble_ex, flush_ifid and flush_idex are all low.
- R2: When the producer in the memory stage writes a nonzero destination equal to an execute operand's source, that operand's select is 2'b10 (memory-stage bypass).
- R3: When only the writeback-stage producer writes a nonzero destination equal to an execute operand's source, the select is 2'b01. With no such match the select is 2'b00 (register file).
- R4: When both the memory-stage and writeback-stage producers match the same source, the memory stage wins and the select is 2'b10.
- R5: A producer with destination zero, or one whose write flag is low, never causes a bypass select other than 2'b00. Bypass selection does not depend on the source-use flags.
- R6: stall_front and bubble_ex are high in the cycle in which execute holds a load with a nonzero destination and a valid decode instruction uses a source equal to it. An unused source, or a load to destination zero, causes no stall.
- R7: A load-use stall lasts exactly one cycle. Two cycles after the stall, the held consumer is in execute and its matching operand select is 2'b01.
- R8: When ex_br_taken is high, flush_ifid and flush_idex are high in that cycle. The squashed decode instruction never reaches execute and never acts as a producer for bypassing.
- R9: A taken branch overrides a load-use hazard in the same cycle: stall_front and bubble_ex stay low.
- R10: Without a load-use hazard, stall_front stays low and a new decode instruction enters execute every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_valid | input | 1 | Decode stage holds a valid instruction |
| id_rs1 | input | AW | First source specifier in decode |
| id_rs2 | input | AW | Second source specifier in decode |
| id_use_rs1 | input | 1 | Decode instruction reads its first source |
| id_use_rs2 | input | 1 | Decode instruction reads its second source |
| id_rd | input | AW | Destination specifier in decode |
| id_wr | input | 1 | Decode instruction writes a register |
| id_load | input | 1 | Decode instruction is a load |
| ex_br_taken | input | 1 | Branch in execute resolved taken |
| fwd_sel_a | output | 2 | Execute operand A source: 00 file, 01 writeback, 10 memory |
| fwd_sel_b | output | 2 | Execute operand B source, same encoding |
| stall_front | output | 1 | Hold PC and fetch/decode register |
| bubble_ex | output | 1 | Insert a NOP into execute |
| flush_ifid | output | 1 | Clear the fetch/decode register |
| flush_idex | output | 1 | Clear the decode/execute register |

## Verification
Two functions can fall in the same cycle: a load-use interlock and a taken-branch flush. The bench provokes the overlap in a directed case and again at random. A load is placed in execute, a consumer of its destination is placed in decode, and ex_br_taken is raised in the same cycle. The outputs must show the flush pair high and the stall and bubble low. In later cycles the squashed consumer must never appear as a bypass producer. A second overlap is between bypassing from both older stages at once. It is judged by the memory stage winning the select.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;

  localparam int NUM_SRC = 2;

endpackage

// File: rtl/hzd_ctrl_pipe.sv
module hzd_ctrl_pipe #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          id_valid,
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic [AW-1:0] id_rd,
  input  logic          id_wr,
  input  logic          id_load,
  input  logic          kill_id,
  output logic [AW-1:0] ex_rs1,
  output logic [AW-1:0] ex_rs2,
  output logic [AW-1:0] ex_rd,
  output logic          ex_wr,
  output logic          ex_load,
  output logic [AW-1:0] mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] wb_rd,
  output logic          wb_wr
);

  logic [AW-1:0] ex_rs1_d, ex_rs2_d, ex_rd_d;
  logic          ex_wr_d, ex_load_d;
  logic          adv_en;

  assign adv_en = 1'b1;

  always_comb begin
    if (kill_id || !id_valid) begin
      ex_rs1_d  = '0;
      ex_rs2_d  = '0;
      ex_rd_d   = '0;
      ex_wr_d   = 1'b0;
      ex_load_d = 1'b0;
    end else begin
      ex_rs1_d  = id_rs1;
      ex_rs2_d  = id_rs2;
      ex_rd_d   = id_rd;
      ex_wr_d   = id_wr;
      ex_load_d = id_load;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_rs1  <= '0;
      ex_rs2  <= '0;
      ex_rd   <= '0;
      ex_wr   <= 1'b0;
      ex_load <= 1'b0;
      mem_rd  <= '0;
      mem_wr  <= 1'b0;
      wb_rd   <= '0;
      wb_wr   <= 1'b0;
    end else if (adv_en) begin
      ex_rs1  <= ex_rs1_d;
      ex_rs2  <= ex_rs2_d;
      ex_rd   <= ex_rd_d;
      ex_wr   <= ex_wr_d;
      ex_load <= ex_load_d;
      mem_rd  <= ex_rd;
      mem_wr  <= ex_wr;
      wb_rd   <= mem_rd;
      wb_wr   <= mem_wr;
    end
  end

endmodule

// File: rtl/hzd_fwd_sel.sv
module hzd_fwd_sel
  import hzd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wr,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wr,
  output logic [1:0]    sel
);

  logic     mem_hit, wb_hit;
  fwd_sel_e sel_e;

  assign mem_hit = mem_wr && (mem_rd != '0) && (mem_rd == src);
  assign wb_hit  = wb_wr  && (wb_rd  != '0) && (wb_rd  == src);

  always_comb begin
    if (mem_hit)     sel_e = FWD_MEM;
    else if (wb_hit) sel_e = FWD_WB;
    else             sel_e = FWD_RF;
  end

  assign sel = sel_e;

endmodule

// File: rtl/hzd_interlock.sv
module hzd_interlock
  import hzd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic                        id_valid,
  input  logic [NUM_SRC-1:0][AW-1:0]  id_src,
  input  logic [NUM_SRC-1:0]          id_use,
  input  logic [AW-1:0]               ex_rd,
  input  logic                        ex_wr,
  input  logic                        ex_load,
  input  logic                        br_taken,
  output logic                        stall,
  output logic                        bubble,
  output logic                        flush_ifid,
  output logic                        flush_idex
);

  logic [NUM_SRC-1:0] src_hit;
  logic               load_use;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign src_hit[g] = id_use[g] && (id_src[g] == ex_rd);
  end

  assign load_use   = id_valid && ex_load && ex_wr && (ex_rd != '0) && (|src_hit);
  assign stall      = load_use && !br_taken;
  assign bubble     = stall;
  assign flush_ifid = br_taken;
  assign flush_idex = br_taken;

endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
  import hzd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          id_valid,
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic          id_use_rs1,
  input  logic          id_use_rs2,
  input  logic [AW-1:0] id_rd,
  input  logic          id_wr,
  input  logic          id_load,
  input  logic          ex_br_taken,
  output logic [1:0]    fwd_sel_a,
  output logic [1:0]    fwd_sel_b,
  output logic          stall_front,
  output logic          bubble_ex,
  output logic          flush_ifid,
  output logic          flush_idex
);

  logic [AW-1:0] ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic          ex_wr, ex_load, mem_wr, wb_wr;
  logic          kill_id;

  logic [NUM_SRC-1:0][AW-1:0] id_src;
  logic [NUM_SRC-1:0]         id_use;
  logic [NUM_SRC-1:0][AW-1:0] ex_src;
  logic [NUM_SRC-1:0][1:0]    ex_sel;

  assign id_src = {id_rs2, id_rs1};
  assign id_use = {id_use_rs2, id_use_rs1};
  assign ex_src = {ex_rs2, ex_rs1};
  assign kill_id = bubble_ex || flush_idex;

  hzd_ctrl_pipe #(.AW(AW)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .id_valid (id_valid),
    .id_rs1   (id_rs1),
    .id_rs2   (id_rs2),
    .id_rd    (id_rd),
    .id_wr    (id_wr),
    .id_load  (id_load),
    .kill_id  (kill_id),
    .ex_rs1   (ex_rs1),
    .ex_rs2   (ex_rs2),
    .ex_rd    (ex_rd),
    .ex_wr    (ex_wr),
    .ex_load  (ex_load),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .wb_rd    (wb_rd),
    .wb_wr    (wb_wr)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_fwd
    hzd_fwd_sel #(.AW(AW)) u_sel (
      .src    (ex_src[g]),
      .mem_rd (mem_rd),
      .mem_wr (mem_wr),
      .wb_rd  (wb_rd),
      .wb_wr  (wb_wr),
      .sel    (ex_sel[g])
    );
  end

  assign fwd_sel_a = ex_sel[0];
  assign fwd_sel_b = ex_sel[1];

  hzd_interlock #(.AW(AW)) u_lock (
    .id_valid   (id_valid),
    .id_src     (id_src),
    .id_use     (id_use),
    .ex_rd      (ex_rd),
    .ex_wr      (ex_wr),
    .ex_load    (ex_load),
    .br_taken   (ex_br_taken),
    .stall      (stall_front),
    .bubble     (bubble_ex),
    .flush_ifid (flush_ifid),
    .flush_idex (flush_idex)
  );

endmodule

// File: rtl/pipe_hazard_ctrl_chk.sv
module pipe_hazard_ctrl_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          id_valid,
  input logic          ex_br_taken,
  input logic          stall_front,
  input logic          bubble_ex,
  input logic          flush_idex,
  input logic [1:0]    fwd_sel_a,
  input logic [1:0]    fwd_sel_b,
  input logic          mem_wr,
  input logic [AW-1:0] mem_rd,
  input logic [AW-1:0] wb_rd,
  input logic          ex_wr
);

  AST_FLUSH_BEATS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    ex_br_taken |-> (!stall_front && !bubble_ex)); // R9

  AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    stall_front |=> !stall_front); // R7

  AST_STALL_NEEDS_ID: assert property (@(posedge clk) disable iff (!rst_n)
    stall_front |-> id_valid); // R6

  AST_FWD_MEM_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_sel_a == 2'b10) |-> (mem_wr && mem_rd != '0)); // R2

  AST_FWD_WB_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_sel_b == 2'b01) |-> (wb_rd != '0)); // R5

  AST_SQUASH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_idex |=> !ex_wr); // R8

endmodule

bind pipe_hazard_ctrl pipe_hazard_ctrl_chk #(.AW(AW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .id_valid    (id_valid),
  .ex_br_taken (ex_br_taken),
  .stall_front (stall_front),
  .bubble_ex   (bubble_ex),
  .flush_idex  (flush_idex),
  .fwd_sel_a   (fwd_sel_a),
  .fwd_sel_b   (fwd_sel_b),
  .mem_wr      (mem_wr),
  .mem_rd      (mem_rd),
  .wb_rd       (wb_rd),
  .ex_wr       (ex_wr)
);

// File: tb/pipe_hazard_ctrl_tb_top.sv
`timescale 1ns/1ps
module pipe_hazard_ctrl_tb_top;
  localparam int AW = 5;

  typedef struct packed {
    logic vld, wr, ld, u1, u2;
    logic [AW-1:0] rd, s1, s2;
  } ins_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  ins_t id_q = '0;
  logic br_in = 1'b0;
  logic [1:0] fwd_sel_a, fwd_sel_b;
  logic stall_front, bubble_ex, flush_ifid, flush_idex;

  pipe_hazard_ctrl #(.AW(AW)) dut_i (
    .clk (clk), .rst_n (rst_n),
    .id_valid (id_q.vld), .id_rs1 (id_q.s1), .id_rs2 (id_q.s2),
    .id_use_rs1 (id_q.u1), .id_use_rs2 (id_q.u2),
    .id_rd (id_q.rd), .id_wr (id_q.wr), .id_load (id_q.ld),
    .ex_br_taken (br_in),
    .fwd_sel_a (fwd_sel_a), .fwd_sel_b (fwd_sel_b),
    .stall_front (stall_front), .bubble_ex (bubble_ex),
    .flush_ifid (flush_ifid), .flush_idex (flush_idex)
  );

  ins_t ex_m = '0, mem_m = '0, wb_m = '0;
  bit hold_p = 0, kill_p = 0, s1d = 0, s2d = 0;
  int errs = 0, checks = 0;
  int unsigned seed_v;

  function automatic ins_t mk(bit wr, bit ld, bit u1, bit u2,
                              int rd, int s1, int s2);
    ins_t t;
    t.vld = 1'b1; t.wr = wr | ld; t.ld = ld; t.u1 = u1; t.u2 = u2;
    t.rd = AW'(rd); t.s1 = AW'(s1); t.s2 = AW'(s2);
    return t;
  endfunction

  function automatic bit hit(ins_t p, logic [AW-1:0] s);
    return p.wr && (p.rd != '0) && (p.rd == s);
  endfunction

  function automatic logic [1:0] fexp(logic [AW-1:0] s);
    if (hit(mem_m, s)) return 2'b10;
    if (hit(wb_m, s))  return 2'b01;
    return 2'b00;
  endfunction

  function automatic string ftag(logic [AW-1:0] s, logic [1:0] e);
    if (e == 2'b10 && hit(wb_m, s)) return "R4";
    if (e == 2'b10) return "R2";
    if (e == 2'b01 && s2d) return "R7";
    if (e == 2'b01) return "R3";
    return "R5";
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic cycle(ins_t n, bit br);
    logic [1:0] ea, eb;
    bit raw, st;
    string stag;
    @(negedge clk);
    id_q = n; br_in = br;
    #1;
    ea = fexp(ex_m.s1);
    eb = fexp(ex_m.s2);
    raw = id_q.vld && ex_m.ld && ex_m.wr && (ex_m.rd != '0) &&
          ((id_q.u1 && id_q.s1 == ex_m.rd) || (id_q.u2 && id_q.s2 == ex_m.rd));
    st = raw && !br;
    chk(fwd_sel_a == ea, ftag(ex_m.s1, ea), "fwd_sel_a", fwd_sel_a, ea);
    chk(fwd_sel_b == eb, ftag(ex_m.s2, eb), "fwd_sel_b", fwd_sel_b, eb);
    if (st) stag = "R6";
    else if (raw) stag = "R9";
    else if (s1d) stag = "R7";
    else stag = "R10";
    chk(stall_front == st && bubble_ex == st, stag, "stall/bubble",
        {stall_front, bubble_ex}, {st, st});
    chk(flush_ifid == br && flush_idex == br, "R8", "flush pair",
        {flush_ifid, flush_idex}, {br, br});
    @(posedge clk);
    wb_m = mem_m; mem_m = ex_m;
    ex_m = (br || st || !id_q.vld) ? '0 : id_q;
    hold_p = st; kill_p = br;
    s2d = s1d; s1d = st;
  endtask

  task automatic issue(ins_t n, bit br);
    while (hold_p) cycle(id_q, 1'b0);
    while (kill_p) cycle('0, 1'b0);
    cycle(n, br);
  endtask

  initial begin
    #(4 * 150000);
    errs++; checks++;
    $display("FAIL R10 watchdog expired: got %0d expected %0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    seed_v = $urandom(32'd4711);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(fwd_sel_a == 2'b00 && fwd_sel_b == 2'b00, "R1", "selects after reset",
        {fwd_sel_a, fwd_sel_b}, 0);
    chk({stall_front, bubble_ex, flush_ifid, flush_idex} == 4'b0, "R1",
        "controls after reset", {stall_front, bubble_ex, flush_ifid, flush_idex}, 0);

    // R2/R4: two writers of r3 then consumer of r3 on both ports
    issue(mk(1,0,1,1,3,1,2), 0);
    issue(mk(1,0,1,1,3,4,5), 0);
    issue(mk(1,0,1,1,6,3,3), 0);
    repeat (3) issue('0, 0);
    // R3: producer, gap, consumer
    issue(mk(1,0,1,1,7,1,1), 0);
    issue(mk(0,0,0,0,0,0,0), 0);
    issue(mk(1,0,1,1,8,7,2), 0);
    repeat (3) issue('0, 0);
    // R5: writes to r0 and non-writing producer
    issue(mk(1,0,1,1,0,1,2), 0);
    issue(mk(0,0,1,1,9,1,2), 0);
    issue(mk(1,0,1,1,4,0,9), 0);
    issue(mk(1,1,1,1,0,1,1), 0);
    issue(mk(1,0,1,1,5,0,0), 0);
    repeat (3) issue('0, 0);
    // R6/R7: load then dependent consumer, plus unused-source case
    issue(mk(1,1,1,0,10,1,0), 0);
    issue(mk(1,0,1,1,11,2,10), 0);
    issue(mk(1,1,1,0,12,1,0), 0);
    issue(mk(1,0,1,0,13,2,12), 0);
    repeat (4) issue('0, 0);
    // R9/R8: load-use coinciding with taken branch
    issue(mk(1,1,1,0,14,1,0), 0);
    issue(mk(1,0,1,1,15,14,14), 1);
    issue(mk(1,0,1,1,16,15,15), 0);
    repeat (4) issue('0, 0);

    // constrained random on a small register range
    for (int i = 0; i < 3000; i++) begin
      ins_t t;
      bit br;
      t = mk($urandom_range(0,3) != 0, $urandom_range(0,2) == 0,
             $urandom_range(0,3) != 0, $urandom_range(0,1) == 1,
             $urandom_range(0,3), $urandom_range(0,3), $urandom_range(0,3));
      if ($urandom_range(0,7) == 0) t = '0;
      br = ($urandom_range(0,9) == 0);
      issue(t, br);
    end
    repeat (4) issue('0, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule